// File: doc/BRIEF.md
# Dual-Core Peripheral Interrupt Router

This block sits between a bank of peripheral interrupt lines and the interrupt inputs of two processor cores. Every source has a small routing register that holds a two-bit core-enable field. Each bit opens the path from that source to one core. A source can therefore reach core 0, core 1, both cores at once, or neither.

Software configures the router through a 16-bit register port. Each request on that port carries the number of the core that issued it. A read-only identity register returns that number, so a core can build its own enable mask as `1 << id` and route a source to itself. All routing fields clear on reset, so nothing is forwarded until software has set up a route. This applies even on a system with a single core. The routed outputs are combinational from the interrupt inputs. Only the configuration is held in registers.

Top module: `irq_router`

## Requirements
- R1: After reset every routing field is 0, both routed output vectors are all-zero for any input pattern, and the read data is 0.
- R2: Routed output `irq_core0[n]` equals `irq_in[n]` AND bit 0 of routing field n, combinationally.
- R3: Routed output `irq_core1[n]` equals `irq_in[n]` AND bit 1 of routing field n, combinationally.
- R4: With field value 3, a source drives both cores in the same cycle.
- R5: Writing 0 to a routing register stops that source from reaching either core, starting with the cycle after the write.
- R6: Routing register n is at byte address 0x80 + 2*n. Write data bits [1:0] form its enable field, with bit 0 for core 0 and bit 1 for core 1. A read returns the field in bits [1:0].
- R7: Bits [15:2] of a routing register read as 0, and write data in those bits has no effect.
- R8: A read at byte address 0x4 returns the requester's `bus_core` value in bit 0, with zeros above it. Writes to 0x4 change nothing.
- R9: Odd addresses, addresses below 0x80 other than 0x4, and indices of NUM_SRC and above read as 0, and writes to them change no routing field.
- R10: Read data appears on `bus_rdata` in the cycle after a read request (`bus_en`=1, `bus_we`=0). It is 0 in the cycle after any other bus cycle, and a read returns the value from before a write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_core | input | 1 | Number of the requesting core |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| irq_in | input | NUM_SRC | Peripheral interrupt lines |
| irq_core0 | output | NUM_SRC | Lines routed to core 0 |
| irq_core1 | output | NUM_SRC | Lines routed to core 1 |

## Verification
The bench builds the router with NUM_SRC = 6 and ADDR_W = 9. With that setting, all four field values can be applied to every source and combined with all 64 input patterns. The full 512-byte address space can also be swept. That sweep covers every odd offset, the out-of-range indices just past the last source, and the identity register for both requesters. It then confirms, at the outputs and by readback, that no stray write changed a route.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int NUM_CORES   = 2;
    localparam int DATA_W      = 16;
    localparam int ROUTE_BASE  = 'h80;
    localparam int CORE_ID_OFS = 'h4;

    typedef logic [NUM_CORES-1:0] route_t;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
    parameter int NUM_SRC = 112,
    parameter int ADDR_W  = 9,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              route_hit,
    output logic [IDX_W-1:0]  route_idx,
    output logic              core_hit
);
    import irq_router_pkg::*;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] half;

    always_comb begin
        offset    = addr - ADDR_W'(ROUTE_BASE);
        half      = offset >> 1;
        route_hit = (addr >= ADDR_W'(ROUTE_BASE)) && !offset[0]
                    && (half < ADDR_W'(NUM_SRC));
        route_idx = half[IDX_W-1:0];
        core_hit  = (addr == ADDR_W'(CORE_ID_OFS));
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
    parameter int NUM_SRC = 112,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [IDX_W-1:0]                        wr_idx,
    input  irq_router_pkg::route_t                  wr_field,
    output irq_router_pkg::route_t [NUM_SRC-1:0]    routes
);
    import irq_router_pkg::*;

    typedef struct packed {
        route_t [NUM_SRC-1:0] field;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d.field[wr_idx] = wr_field;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign routes = regs_q.field;
endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout #(
    parameter int NUM_SRC = 112
) (
    input  logic [NUM_SRC-1:0]                      irq_in,
    input  irq_router_pkg::route_t [NUM_SRC-1:0]    routes,
    output logic [irq_router_pkg::NUM_CORES-1:0][NUM_SRC-1:0] irq_out
);
    import irq_router_pkg::*;

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign irq_out[k][n] = irq_in[n] & routes[n][k];
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NUM_SRC = 112,
    parameter int ADDR_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    input  logic               bus_core,
    output logic [15:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic [NUM_SRC-1:0] irq_core0,
    output logic [NUM_SRC-1:0] irq_core1
);
    import irq_router_pkg::*;

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic                          route_hit;
    logic                          core_hit;
    logic [IDX_W-1:0]              route_idx;
    route_t [NUM_SRC-1:0]          routes;
    logic [NUM_CORES-1:0][NUM_SRC-1:0] irq_out;
    logic                          wr_en;

    irq_route_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_decode (
        .addr      (bus_addr),
        .route_hit (route_hit),
        .route_idx (route_idx),
        .core_hit  (core_hit)
    );

    assign wr_en = bus_en && bus_we && route_hit;

    irq_route_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (route_idx),
        .wr_field (bus_wdata[NUM_CORES-1:0]),
        .routes   (routes)
    );

    irq_route_fanout #(.NUM_SRC(NUM_SRC)) u_fanout (
        .irq_in  (irq_in),
        .routes  (routes),
        .irq_out (irq_out)
    );

    assign irq_core0 = irq_out[0];
    assign irq_core1 = irq_out[1];

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (bus_en && !bus_we) begin
            if (core_hit) begin
                rd_d.rdata = {{(DATA_W-1){1'b0}}, bus_core};
            end else if (route_hit) begin
                rd_d.rdata = {{(DATA_W-NUM_CORES){1'b0}}, routes[route_idx]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC = 112,
    parameter int ADDR_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [15:0]        bus_wdata,
    input logic               bus_core,
    input logic [15:0]        bus_rdata,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [NUM_SRC-1:0] irq_core0,
    input logic [NUM_SRC-1:0] irq_core1
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] slot;
    logic              mapped;
    logic              is_read;
    logic              dead_read;
    logic              zero_wr;
    logic              zero_q;
    logic [IDX_W-1:0]  zidx_q;

    always_comb begin
        off       = bus_addr - ADDR_W'(128);
        slot      = off >> 1;
        mapped    = (bus_addr >= ADDR_W'(128)) && !off[0] && (slot < ADDR_W'(NUM_SRC));
        is_read   = bus_en && !bus_we;
        dead_read = is_read && !mapped && (bus_addr != ADDR_W'(4));
        zero_wr   = bus_en && bus_we && mapped && (bus_wdata[1:0] == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q <= 1'b0;
            zidx_q <= '0;
        end else begin
            zero_q <= zero_wr;
            zidx_q <= slot[IDX_W-1:0];
        end
    end

    // R1
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_core0 == '0 && irq_core1 == '0 && bus_rdata == '0));

    // R2
    assert_core0_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_core0 & ~irq_in) == '0);

    // R3
    assert_core1_needs_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_core1 & ~irq_in) == '0);

    // R5
    assert_zero_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |-> (!irq_core0[zidx_q] && !irq_core1[zidx_q]));

    // R7
    assert_upper_bits_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:2] == '0);

    // R8
    assert_core_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && bus_addr == ADDR_W'(4)) |=> bus_rdata == {15'b0, $past(bus_core)});

    // R9
    assert_dead_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dead_read |=> bus_rdata == '0);

    // R10
    assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> bus_rdata == '0);
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
    localparam int NUM_SRC = 6;
    localparam int ADDR_W  = 9;
    localparam int MAX_CYC = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_en = 1'b0;
    logic               bus_we = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [15:0]        bus_wdata = '0;
    logic               bus_core = 1'b0;
    logic [15:0]        bus_rdata;
    logic [NUM_SRC-1:0] irq_in = '0;
    logic [NUM_SRC-1:0] irq_core0;
    logic [NUM_SRC-1:0] irq_core1;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    logic [1:0] model [NUM_SRC];

    always #4 clk = ~clk;

    irq_router #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u0 (.*);

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYC) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, MAX_CYC);
            report();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [15:0] data, logic core);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr);
        bus_wdata = data; bus_core = core;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(int addr, logic core, output logic [15:0] data);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr); bus_core = core;
        @(negedge clk);
        bus_en = 1'b0;
        data = bus_rdata;
    endtask

    function automatic logic [NUM_SRC-1:0] expect_out(logic [NUM_SRC-1:0] in, int k);
        logic [NUM_SRC-1:0] r;
        for (int n = 0; n < NUM_SRC; n++) r[n] = in[n] & model[n][k];
        return r;
    endfunction

    task automatic check_outs(string req, logic [NUM_SRC-1:0] in);
        irq_in = in;
        #1;
        chk({req, " core0"}, 32'(irq_core0), 32'(expect_out(in, 0)));
        chk({req, " core1"}, 32'(irq_core1), 32'(expect_out(in, 1)));
    endtask

    task automatic check_all_routes(string req);
        logic [15:0] d;
        for (int n = 0; n < NUM_SRC; n++) begin
            rd('h80 + 2 * n, 1'b0, d);
            chk(req, 32'(d), 32'(model[n]));
        end
        check_outs(req, '1);
    endtask

    initial begin
        logic [15:0] d;
        for (int n = 0; n < NUM_SRC; n++) model[n] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        chk("R1 rdata", 32'(bus_rdata), 32'h0);
        check_outs("R1", '1);
        check_all_routes("R1");

        // R2 R3 R4 R6 R7: every field value on every source, all input patterns
        for (int n = 0; n < NUM_SRC; n++) begin
            for (int v = 0; v < 4; v++) begin
                wr('h80 + 2 * n, 16'(16'hA5F0 | v), n[0]);
                model[n] = 2'(v);
                rd('h80 + 2 * n, 1'b1, d);
                chk("R6 R7 readback", 32'(d), 32'(v));
                for (int p = 0; p < (1 << NUM_SRC); p++) begin
                    check_outs(v == 3 ? "R4" : "R2 R3", NUM_SRC'(p));
                end
            end
        end

        // R5: zero write blocks a source in the next cycle
        for (int n = 0; n < NUM_SRC; n++) begin
            wr('h80 + 2 * n, 16'h0003, 1'b0);
            model[n] = 2'b11;
        end
        wr('h80 + 2 * 2, 16'hFFFC, 1'b1);
        model[2] = 2'b00;
        check_outs("R5", '1);
        chk("R5 src2 core0", 32'(irq_core0[2]), 32'h0);
        chk("R5 src2 core1", 32'(irq_core1[2]), 32'h0);

        // R10: read after a same-cycle write returns old value; idle gives zero
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'('h80); bus_core = 1'b0;
        @(negedge clk);
        chk("R10 read data", 32'(bus_rdata), 32'h3);
        bus_en = 1'b0;
        @(negedge clk);
        chk("R10 idle zero", 32'(bus_rdata), 32'h0);
        wr('h80, 16'h0001, 1'b0);
        model[0] = 2'b01;
        #1;
        chk("R10 after write zero", 32'(bus_rdata), 32'h0);

        // R8: core identity register
        rd('h4, 1'b0, d);
        chk("R8 core0 id", 32'(d), 32'h0);
        rd('h4, 1'b1, d);
        chk("R8 core1 id", 32'(d), 32'h1);
        wr('h4, 16'hFFFF, 1'b0);
        rd('h4, 1'b0, d);
        chk("R8 id after write", 32'(d), 32'h0);

        // R9: every unmapped address reads zero and ignores writes
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            if (a == 'h4) continue;
            if (a >= 'h80 && a < 'h80 + 2 * NUM_SRC && (a % 2) == 0) continue;
            wr(a, 16'hFFFF, a[0]);
            rd(a, a[1], d);
            chk("R9 unmapped read", 32'(d), 32'h0);
        end
        check_all_routes("R9");

        report();
    end
endmodule